// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits in front of the data memory of a small 8-bit controller core. Each access carries a 7-bit offset from the instruction. Two bank bits held in the core's status register extend that offset to an 8-bit address across four 128-byte banks. Offset 00h is a virtual slot with no storage. Touching it redirects the access to the full 8-bit address held in the pointer register. Only banks 0 and 1 exist. A set upper bank bit selects a bank that reads as zero and drops writes.

The decoder holds the general-purpose static RAM, the status register and the pointer register. Every other special-function slot belongs to a peripheral outside the block. For those slots it raises one bit of a one-hot select and passes the matching peripheral read lane back to the core. Several heavily used registers have the same physical location at the same offset in both banks. Holes and absent registers read back as zero.

Top module: `data_file_front`

## Requirements
- R1: A direct access (offset not 00h) addresses location {status[6:5], offset}; bank 0 offset 20h and bank 1 offset 20h (A0h) are separate RAM bytes.
- R2: When status bit 6 is set, every direct access reads 00h, raises no peripheral select and changes no stored state.
- R3: General-purpose RAM occupies 20h–7Fh and A0h–BFh. Locations C0h–FFh, reached directly or through the pointer, read 00h and ignore writes.
- R4: An access at offset 00h uses all 8 bits of the pointer as the address, whatever the status bank bits hold.
- R5: A pointer value of 00h or 80h makes the offset-00h access read 00h and write nothing.
- R6: The status register (offsets 03h/83h) and the pointer register (04h/84h) are single registers reachable from both banks.
- R7: A write to status changes the bank bits used by the very next access.
- R8: per_sel is one-hot or zero. Bit index by location: 0 = 02h/82h, 1 = 0Ah/8Ah, 2 = 0Bh/8Bh, 3 = 01h, 4 = 81h, 5–7 = 05h–07h, 8–10 = 85h–87h, 11 = 0Ch, 12 = 8Ch, 13 = 8Eh, 14–18 = 0Eh–12h, 19 = 92h, 20 = 13h, 21 = 14h, 22 = 93h, 23 = 94h, 24–26 = 15h–17h, 27 = 1Eh, 28 = 1Fh, 29 = 9Fh. per_we is high exactly when wr_en is high and a select bit is raised.
- R9: On a peripheral location, rd_data equals byte lane k of per_rdata (bits 8k+7:8k), where k is the select index from R8.
- R10: Offsets with no register (for example 08h, 09h, 0Dh, 18h–1Dh, 88h), and the converter locations 1Eh, 1Fh and 9Fh when HAS_ADC is 0, read 00h and raise no select.
- R11: Reset sets status to 18h and the pointer to 00h. Reset asserts asynchronously on rst_n low and releases on the second clock edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_addr | input | 7 | Offset within the bank, from the instruction |
| wr_en | input | 1 | Write the addressed location on the next edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| per_sel | output | 30 | One-hot peripheral register select |
| per_we | output | 1 | Peripheral write strobe |
| per_rdata | input | 240 | Peripheral read lanes, 8 bits per select index |
| status_o | output | 8 | Current status register |
| ptr_o | output | 8 | Current pointer register |

## Verification
The bench tests the pointer slot in its awkward positions. It points it at itself in bank 1 (80h), at the unimplemented C0h range, and at status while the bank bits select an absent bank. That last one is the only way back out. A decoder that indexed RAM from the pointer's low 7 bits would corrupt bank 0 RAM. One that mixed the status bank bits into pointer addresses would read the wrong byte. The bench checks that a status write steers the access in the very next cycle; a one-cycle-late bank register selects the wrong peripheral. Mirrored slots must give the same select bit in both banks. Absent converter slots must stay silent.

// File: rtl/dfront_pkg.sv
package dfront_pkg;

  localparam int OFF_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int NSLOT   = 30;
  localparam int SLOT_W  = $clog2(NSLOT);

  // general-purpose RAM windows, as offsets within their bank
  localparam logic [OFF_W-1:0] GPR0_LO = 7'h20;
  localparam logic [OFF_W-1:0] GPR0_HI = 7'h7F;
  localparam logic [OFF_W-1:0] GPR1_LO = 7'h20;
  localparam logic [OFF_W-1:0] GPR1_HI = 7'h3F;
  localparam int GPR0_N    = int'(GPR0_HI) - int'(GPR0_LO) + 1;
  localparam int GPR1_N    = int'(GPR1_HI) - int'(GPR1_LO) + 1;
  localparam int GPR_DEPTH = GPR0_N + GPR1_N;
  localparam int GPR_IW    = $clog2(GPR_DEPTH);

  localparam logic [OFF_W-1:0] OFF_VIRT   = 7'h00;
  localparam logic [OFF_W-1:0] OFF_STATUS = 7'h03;
  localparam logic [OFF_W-1:0] OFF_PTR    = 7'h04;

  typedef enum logic [2:0] {
    RG_HOLE,
    RG_NULL,
    RG_GPR,
    RG_STATUS,
    RG_PTR,
    RG_PERIPH
  } region_e;

  // peripheral select indices
  localparam int SL_PCLO   = 0;
  localparam int SL_PCHI   = 1;
  localparam int SL_IRQCTL = 2;
  localparam int SL_TICK   = 3;
  localparam int SL_OPT    = 4;
  localparam int SL_PIN0   = 5;
  localparam int SL_DIR0   = 8;
  localparam int SL_IRQFLG = 11;
  localparam int SL_IRQEN  = 12;
  localparam int SL_PWR    = 13;
  localparam int SL_TMA0   = 14;
  localparam int SL_TMBPER = 19;
  localparam int SL_SBUF   = 20;
  localparam int SL_SCTL   = 21;
  localparam int SL_SADR   = 22;
  localparam int SL_SSTA   = 23;
  localparam int SL_CAP0   = 24;
  localparam int SL_CVRES  = 27;
  localparam int SL_CVCT0  = 28;
  localparam int SL_CVCT1  = 29;

  // returns {hit, index}
  function automatic logic [SLOT_W:0] slot_lookup(input logic hi_bank,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic adc_ok);
    logic [SLOT_W:0] r;
    logic [SLOT_W-1:0] idx;
    logic hit;
    hit = 1'b1;
    idx = '0;
    case ({hi_bank, off})
      8'h02, 8'h82: idx = SLOT_W'(SL_PCLO);
      8'h0A, 8'h8A: idx = SLOT_W'(SL_PCHI);
      8'h0B, 8'h8B: idx = SLOT_W'(SL_IRQCTL);
      8'h01:        idx = SLOT_W'(SL_TICK);
      8'h81:        idx = SLOT_W'(SL_OPT);
      8'h05, 8'h06, 8'h07: idx = SLOT_W'(SL_PIN0 + int'(off) - 5);
      8'h85, 8'h86, 8'h87: idx = SLOT_W'(SL_DIR0 + int'(off) - 5);
      8'h0C:        idx = SLOT_W'(SL_IRQFLG);
      8'h8C:        idx = SLOT_W'(SL_IRQEN);
      8'h8E:        idx = SLOT_W'(SL_PWR);
      8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12:
                    idx = SLOT_W'(SL_TMA0 + int'(off) - 14);
      8'h92:        idx = SLOT_W'(SL_TMBPER);
      8'h13:        idx = SLOT_W'(SL_SBUF);
      8'h14:        idx = SLOT_W'(SL_SCTL);
      8'h93:        idx = SLOT_W'(SL_SADR);
      8'h94:        idx = SLOT_W'(SL_SSTA);
      8'h15, 8'h16, 8'h17: idx = SLOT_W'(SL_CAP0 + int'(off) - 21);
      8'h1E: begin idx = SLOT_W'(SL_CVRES); hit = adc_ok; end
      8'h1F: begin idx = SLOT_W'(SL_CVCT0); hit = adc_ok; end
      8'h9F: begin idx = SLOT_W'(SL_CVCT1); hit = adc_ok; end
      default: hit = 1'b0;
    endcase
    r = {hit, idx};
    return r;
  endfunction

endpackage

// File: rtl/dfront_addr.sv
module dfront_addr
  import dfront_pkg::*;
(
  input  logic [OFF_W-1:0]  dir_off,
  input  logic [1:0]        bank_bits,
  input  logic [BYTE_W-1:0] ptr,
  output logic [1:0]        eff_bank,
  output logic [OFF_W-1:0]  eff_off,
  output logic              via_ptr
);

  always_comb begin
    via_ptr = (dir_off == OFF_VIRT);
    if (via_ptr) begin
      // pointer carries its own bank bit; upper bank bit is never set
      eff_bank = {1'b0, ptr[BYTE_W-1]};
      eff_off  = ptr[OFF_W-1:0];
    end else begin
      eff_bank = bank_bits;
      eff_off  = dir_off;
    end
  end

endmodule

// File: rtl/dfront_class.sv
module dfront_class
  import dfront_pkg::*;
#(
  parameter bit HAS_ADC = 1'b0
) (
  input  logic [1:0]        eff_bank,
  input  logic [OFF_W-1:0]  eff_off,
  output region_e           region,
  output logic [GPR_IW-1:0] gpr_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [NSLOT-1:0]  slot_oh
);

  logic adc_ok;
  logic [SLOT_W:0] look;
  logic in_gpr0, in_gpr1;
  logic [OFF_W-1:0] rel0, rel1;

  generate
    if (HAS_ADC) begin : g_adc
      assign adc_ok = 1'b1;
    end else begin : g_noadc
      assign adc_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    look    = slot_lookup(eff_bank[0], eff_off, adc_ok);
    in_gpr0 = (eff_bank == 2'd0) && (eff_off >= GPR0_LO) && (eff_off <= GPR0_HI);
    in_gpr1 = (eff_bank == 2'd1) && (eff_off >= GPR1_LO) && (eff_off <= GPR1_HI);
    rel0    = eff_off - GPR0_LO;
    rel1    = eff_off - GPR1_LO;
    gpr_idx = '0;
    region  = RG_HOLE;
    if (eff_bank[1]) begin
      region = RG_HOLE;
    end else if (eff_off == OFF_VIRT) begin
      region = RG_NULL;
    end else if (eff_off == OFF_STATUS) begin
      region = RG_STATUS;
    end else if (eff_off == OFF_PTR) begin
      region = RG_PTR;
    end else if (in_gpr0) begin
      region  = RG_GPR;
      gpr_idx = GPR_IW'(rel0);
    end else if (in_gpr1) begin
      region  = RG_GPR;
      gpr_idx = GPR_IW'(int'(rel1) + GPR0_N);
    end else if (look[SLOT_W]) begin
      region = RG_PERIPH;
    end
    slot_idx = look[SLOT_W-1:0];
  end

  generate
    for (genvar k = 0; k < NSLOT; k++) begin : g_oh
      assign slot_oh[k] = (region == RG_PERIPH) && (slot_idx == SLOT_W'(k));
    end
  endgenerate

  // R8: never more than one peripheral selected
  always_comb begin
    if (!$isunknown(slot_oh))
      p_sel_onehot_r8: assert ($onehot0(slot_oh));
  end

endmodule

// File: rtl/dfront_gpr.sv
module dfront_gpr #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/data_file_front.sv
module data_file_front
  import dfront_pkg::*;
#(
  parameter bit          HAS_ADC    = 1'b0,
  parameter logic [7:0]  STATUS_RST = 8'h18,
  parameter logic [7:0]  PTR_RST    = 8'h00
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [OFF_W-1:0]        dir_addr,
  input  logic                    wr_en,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic [BYTE_W-1:0]       rd_data,
  output logic [NSLOT-1:0]        per_sel,
  output logic                    per_we,
  input  logic [NSLOT*BYTE_W-1:0] per_rdata,
  output logic [BYTE_W-1:0]       status_o,
  output logic [BYTE_W-1:0]       ptr_o
);

  localparam int BANK_LSB = 5;

  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [BYTE_W-1:0] status_q, status_d, ptr_q, ptr_d;
  logic              status_en, ptr_en, gpr_we;
  logic [1:0]        eff_bank;
  logic [OFF_W-1:0]  eff_off;
  logic              via_ptr;
  region_e           region;
  logic [GPR_IW-1:0] gpr_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic [NSLOT-1:0]  slot_oh;
  logic [BYTE_W-1:0] gpr_rdata;

  dfront_addr u_addr (
    .dir_off  (dir_addr),
    .bank_bits(status_q[BANK_LSB+1:BANK_LSB]),
    .ptr      (ptr_q),
    .eff_bank (eff_bank),
    .eff_off  (eff_off),
    .via_ptr  (via_ptr)
  );

  dfront_class #(.HAS_ADC(HAS_ADC)) u_class (
    .eff_bank(eff_bank),
    .eff_off (eff_off),
    .region  (region),
    .gpr_idx (gpr_idx),
    .slot_idx(slot_idx),
    .slot_oh (slot_oh)
  );

  dfront_gpr #(.DEPTH(GPR_DEPTH), .WIDTH(BYTE_W)) u_gpr (
    .clk  (clk),
    .we   (gpr_we),
    .idx  (gpr_idx),
    .wdata(wr_data),
    .rdata(gpr_rdata)
  );

  // next-state
  always_comb begin
    status_en = wr_en && (region == RG_STATUS);
    ptr_en    = wr_en && (region == RG_PTR);
    gpr_we    = wr_en && (region == RG_GPR);
    status_d  = status_en ? wr_data : status_q;
    ptr_d     = ptr_en    ? wr_data : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      status_q <= STATUS_RST;
      ptr_q    <= PTR_RST;
    end else begin
      status_q <= status_d;
      ptr_q    <= ptr_d;
    end
  end

  // read path and peripheral strobes
  always_comb begin
    per_sel = slot_oh;
    per_we  = wr_en && (region == RG_PERIPH);
    unique case (region)
      RG_GPR:    rd_data = gpr_rdata;
      RG_STATUS: rd_data = status_q;
      RG_PTR:    rd_data = ptr_q;
      RG_PERIPH: rd_data = per_rdata[slot_idx*BYTE_W +: BYTE_W];
      default:   rd_data = '0;
    endcase
  end

  assign status_o = status_q;
  assign ptr_o    = ptr_q;

  // R2: an absent bank is silent
  p_bank_hi_silent_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dir_addr != OFF_VIRT && status_q[BANK_LSB+1]) |->
      (rd_data == '0 && per_sel == '0 && !per_we));

  // R5: pointer aimed at the virtual slot goes nowhere
  p_null_silent_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dir_addr == OFF_VIRT && ptr_q[OFF_W-1:0] == OFF_VIRT) |->
      (rd_data == '0 && !per_we && !gpr_we));

  // R7: status write lands on the next edge
  p_status_wr_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && region == RG_STATUS) |=> (status_q == $past(wr_data)));

  // R6: pointer write lands on the next edge from either bank
  p_ptr_wr_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && region == RG_PTR) |=> (ptr_q == $past(wr_data)));

  // R3: writes into C0h-FFh change no RAM and no register
  p_upper_hole_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (eff_bank == 2'd1 && eff_off >= 7'h40) |-> (!gpr_we && !per_we));

endmodule

// File: tb/data_file_front_test.sv
module data_file_front_test;
  import dfront_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] dir_addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [NSLOT-1:0] per_sel;
  logic per_we;
  logic [NSLOT*8-1:0] per_rdata;
  logic [7:0] status_o, ptr_o;

  always #2 clk = ~clk;  // 250 MHz

  data_file_front uut (
    .clk(clk), .rst_n(rst_n), .dir_addr(dir_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .per_sel(per_sel), .per_we(per_we),
    .per_rdata(per_rdata), .status_o(status_o), .ptr_o(ptr_o)
  );

  function automatic logic [7:0] lane_val(int i);
    return 8'(8'h40 + 3 * i);
  endfunction

  initial begin
    for (int i = 0; i < NSLOT; i++) per_rdata[i*8 +: 8] = lane_val(i);
  end

  typedef struct packed {
    logic       wr;
    logic [6:0] a;
    logic [7:0] d;    // write data, or expected read data
    logic [3:0] req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'h20, 8'h11, 4'd1},  // R1 bank0 20h
    '{1'b1, 7'h7F, 8'h22, 4'd3},  // R3 top of bank0 RAM
    '{1'b0, 7'h20, 8'h11, 4'd1},
    '{1'b0, 7'h7F, 8'h22, 4'd3},
    '{1'b1, 7'h03, 8'h38, 4'd7},  // R7 switch to bank1
    '{1'b1, 7'h20, 8'h33, 4'd1},  // A0h
    '{1'b0, 7'h20, 8'h33, 4'd1},
    '{1'b0, 7'h03, 8'h38, 4'd6},  // R6 status at 83h
    '{1'b1, 7'h40, 8'h55, 4'd3},  // C0h write dropped
    '{1'b0, 7'h40, 8'h00, 4'd3},
    '{1'b1, 7'h04, 8'hA0, 4'd6},  // pointer via 84h
    '{1'b1, 7'h03, 8'h18, 4'd7},  // back to bank0
    '{1'b0, 7'h04, 8'hA0, 4'd6},  // pointer at 04h
    '{1'b0, 7'h20, 8'h11, 4'd1},
    '{1'b0, 7'h00, 8'h33, 4'd4},  // R4 reaches A0h from bank0
    '{1'b1, 7'h00, 8'h44, 4'd4},
    '{1'b0, 7'h00, 8'h44, 4'd4},
    '{1'b1, 7'h04, 8'h20, 4'd4},
    '{1'b0, 7'h00, 8'h11, 4'd4},
    '{1'b1, 7'h04, 8'h80, 4'd5},  // R5 pointer at 80h
    '{1'b0, 7'h00, 8'h00, 4'd5},
    '{1'b1, 7'h00, 8'h99, 4'd5},
    '{1'b1, 7'h04, 8'hA0, 4'd5},
    '{1'b0, 7'h00, 8'h44, 4'd5},
    '{1'b1, 7'h04, 8'h03, 4'd2},  // R2 pointer at status
    '{1'b1, 7'h03, 8'h58, 4'd2},  // bank2
    '{1'b0, 7'h20, 8'h00, 4'd2},
    '{1'b1, 7'h20, 8'h77, 4'd2},
    '{1'b0, 7'h00, 8'h58, 4'd2},
    '{1'b1, 7'h00, 8'h18, 4'd2},  // escape via pointer
    '{1'b0, 7'h20, 8'h11, 4'd2},
    '{1'b0, 7'h05, 8'h4F, 4'd9},  // R9 lane 5
    '{1'b0, 7'h0A, 8'h43, 4'd9},  // lane 1
    '{1'b0, 7'h1E, 8'h00, 4'd10}, // R10 absent converter
    '{1'b0, 7'h08, 8'h00, 4'd10},
    '{1'b1, 7'h04, 8'hC5, 4'd3},
    '{1'b0, 7'h00, 8'h00, 4'd3},
    '{1'b1, 7'h03, 8'h38, 4'd9},
    '{1'b0, 7'h05, 8'h58, 4'd9},  // 85h lane 8
    '{1'b0, 7'h1F, 8'h00, 4'd10}, // 9Fh absent
    '{1'b1, 7'h03, 8'h18, 4'd7}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; dir_addr = a; wr_data = d;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(32'(status_o), 32'h18, "R11 status after reset");
    check(32'(ptr_o), 32'h00, "R11 pointer after reset");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].wr, VECS[i].a, VECS[i].wr ? VECS[i].d : 8'h00);
      if (!VECS[i].wr)
        check(32'(rd_data), 32'(VECS[i].d), $sformatf("R%0d vector %0d", VECS[i].req, i));
    end
    drive(1'b0, 7'h01, 8'h00);

    // R8 mirrored slot 0Ah: same select in both banks, strobe with write
    drive(1'b1, 7'h0A, 8'h5A);
    check(32'(per_sel), 32'(1) << 1, "R8 0Ah select bank0");
    check(32'(per_we), 32'd1, "R8 write strobe");
    drive(1'b1, 7'h03, 8'h38);
    drive(1'b1, 7'h0A, 8'h5A);
    check(32'(per_sel), 32'(1) << 1, "R8 8Ah select bank1");
    drive(1'b0, 7'h05, 8'h00);
    check(32'(per_sel), 32'(1) << 8, "R8 85h select");
    check(32'(per_we), 32'd0, "R8 no strobe on read");
    drive(1'b0, 7'h1F, 8'h00);
    check(32'(per_sel), 32'd0, "R10 9Fh no select");

    // R7 status write steers the next access
    drive(1'b1, 7'h03, 8'h18);
    drive(1'b0, 7'h01, 8'h00);
    check(32'(per_sel), 32'(1) << 3, "R7 bank0 right after write");
    drive(1'b1, 7'h03, 8'h38);
    drive(1'b0, 7'h01, 8'h00);
    check(32'(per_sel), 32'(1) << 4, "R7 bank1 right after write");
    drive(1'b0, 7'h08, 8'h00);
    check(32'(per_sel), 32'd0, "R10 88h no select");
    check(32'(rd_data), 32'd0, "R10 88h reads zero");

    // R11 reset mid-run
    drive(1'b1, 7'h04, 8'h5A);
    drive(1'b0, 7'h01, 8'h00);
    check(32'(ptr_o), 32'h5A, "R6 pointer written");
    rst_n = 1'b0;
    #1;
    check(32'(status_o), 32'h18, "R11 async status reset");
    check(32'(ptr_o), 32'h00, "R11 async pointer reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(1'b0, 7'h20, 8'h00);
    check(32'(rd_data), 32'h11, "R1 RAM kept over reset, bank0");

    finish_run();
  end

endmodule